// File: doc/BRIEF.md
# Multi-hop Bypass Request Arbiter

This block is the control unit for one input port of a mesh router that lets a flit cross several routers in a single clock cycle. In the setup cycle, upstream routers on the same row or column broadcast setup requests along one direction. A request from a router that is `d` hops away arrives on lane `d`, for `d` from 1 to `HPC`, the maximum number of hops per cycle. Each request carries the total hop count its flit wants to travel in the next cycle. The block also sees whether a flit in the local buffer wants the same outgoing link.

Every cycle the arbiter picks one claimant. A local flit always wins. Otherwise the nearest qualifying upstream request wins. The arbiter then registers a decision that holds for exactly the following cycle, the traversal cycle:
- **pass**: the incoming flit goes through the crossbar unlatched.
- **land**: the incoming flit is written into this port's buffer.
- **local**: the local flit owns the link.

Losers receive no acknowledgement. An upstream flit that meets a local winner is buffered here and resumes later.

The decision is held as an enumerated state:
- `ARB_IDLE`: no grant.
- `ARB_PASS`: an upstream winner continues past this router.
- `ARB_LAND`: an upstream winner ends its hop run here.
- `ARB_LOCAL`: the local flit wins and nothing arrives from upstream.
- `ARB_LOCAL_HOLD`: the local flit wins and an incoming flit is buffered.

The next state is computed from the current requests only, so any state can be followed by any other state. Every transition is taken on the next edge:
- to `ARB_LOCAL_HOLD` when a local request and a qualifying upstream request are both present;
- to `ARB_LOCAL` when only a local request is present;
- to `ARB_PASS` when the nearest qualifying request has more hops than its lane distance;
- to `ARB_LAND` when that hop count equals the distance;
- to `ARB_IDLE` otherwise.

Top module: `smart_bypass_arbiter`

## Requirements
- R1: During and directly after reset, `byp_en`, `latch_en`, `grant_local` and `grant_dist` are all 0.
- R2: A request on lane `d` (bit `d-1` of `req_valid`, hop count in `req_hops[(d-1)*HW +: HW]`) qualifies only if its hop count is at least `d`. A non-qualifying request produces no grant and no flag.
- R3: When `local_req` is 1, the next cycle shows `grant_local`=1 and `grant_dist`=0, whatever the upstream requests are.
- R4: When the local flit wins and at least one upstream request qualifies, the next cycle shows `latch_en`=1 and `byp_en`=0.
- R5: Without a local request, the qualifying request with the smallest distance wins. `grant_dist` is then one-hot with bit `d-1` set.
- R6: If the upstream winner's hop count exceeds its distance, the next cycle shows `byp_en`=1 and `latch_en`=0.
- R7: If the upstream winner's hop count equals its distance, the next cycle shows `latch_en`=1 and `byp_en`=0.
- R8: Each decision is visible for exactly the one cycle after its requests. With no local request and no qualifying request, all outputs are 0 in the next cycle.
- R9: `{grant_local, grant_dist}` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_req | input | 1 | A locally buffered flit wants the link |
| req_valid | input | HPC | Setup request present, bit d-1 is distance d |
| req_hops | input | HPC*HW | Hop count per lane, HW = clog2(HPC+1) |
| byp_en | output | 1 | Pass the incoming flit through unlatched |
| latch_en | output | 1 | Buffer the incoming flit at this port |
| grant_local | output | 1 | Local flit owns the link |
| grant_dist | output | HPC | One-hot distance of the upstream winner |

## Verification
A wrong state register or next-state choice appears at the ports one cycle after the requests that caused it. It shows either as a wrong pair of `byp_en`/`latch_en` flags or as a grant on the wrong lane, and it never lasts longer than that single cycle. A fault in lane qualification or in the nearest-first scan changes `grant_dist` only for particular combinations of hop counts and valid bits. The bench therefore sweeps every combination of local request, valid bits and hop counts for a three-lane configuration.

// File: rtl/smart_arb_pkg.sv
package smart_arb_pkg;

    typedef enum logic [2:0] {
        ARB_IDLE       = 3'd0,
        ARB_PASS       = 3'd1,
        ARB_LAND       = 3'd2,
        ARB_LOCAL      = 3'd3,
        ARB_LOCAL_HOLD = 3'd4
    } arb_state_e;

endpackage

// File: rtl/smart_req_qualify.sv
module smart_req_qualify #(
    parameter int HPC = 7,
    parameter int HW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HPC-1:0]    req_valid,
    input  logic [HPC*HW-1:0] req_hops,
    output logic [HPC-1:0]    qual,
    output logic [HPC-1:0]    last_hop
);

    // A lane qualifies when its flit travels at least as far as this router.
    for (genvar i = 0; i < HPC; i++) begin : g_lane
        localparam logic [HW-1:0] DIST = HW'(i + 1);
        logic [HW-1:0] hops;
        assign hops        = req_hops[i*HW +: HW];
        assign qual[i]     = req_valid[i] && (hops >= DIST);
        assign last_hop[i] = req_valid[i] && (hops == DIST);
    end

    AST_QUAL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((qual & ~req_valid) == '0)); // R2

endmodule

// File: rtl/smart_near_pick.sv
module smart_near_pick #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] qual,
    output logic [N-1:0] pick,
    output logic         any
);

    // Nearest lane first: the lowest index wins.
    always_comb begin
        logic seen;
        seen = 1'b0;
        pick = '0;
        for (int i = 0; i < N; i++) begin
            if (qual[i] && !seen) begin
                pick[i] = 1'b1;
            end
            seen = seen | qual[i];
        end
    end

    assign any = |qual;

    AST_PICK_FROM_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((pick & ~qual) == '0)); // R5
    AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(pick) && (any == (pick != '0)))); // R5

endmodule

// File: rtl/smart_bypass_fsm.sv
module smart_bypass_fsm
    import smart_arb_pkg::*;
#(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         local_req,
    input  logic         up_any,
    input  logic [N-1:0] up_pick,
    input  logic         up_last,
    output logic         byp_en,
    output logic         latch_en,
    output logic         grant_local,
    output logic [N-1:0] grant_dist
);

    arb_state_e state_q, state_d;
    logic [N-1:0] dist_q;

    always_comb begin
        if (local_req && up_any)  state_d = ARB_LOCAL_HOLD;
        else if (local_req)       state_d = ARB_LOCAL;
        else if (up_any && up_last) state_d = ARB_LAND;
        else if (up_any)          state_d = ARB_PASS;
        else                      state_d = ARB_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            dist_q  <= '0;
        end else begin
            state_q <= state_d;
            dist_q  <= local_req ? '0 : up_pick;
        end
    end

    always_comb begin
        byp_en      = 1'b0;
        latch_en    = 1'b0;
        grant_local = 1'b0;
        grant_dist  = '0;
        unique case (state_q)
            ARB_IDLE: ;
            ARB_PASS: begin
                byp_en     = 1'b1;
                grant_dist = dist_q;
            end
            ARB_LAND: begin
                latch_en   = 1'b1;
                grant_dist = dist_q;
            end
            ARB_LOCAL: grant_local = 1'b1;
            ARB_LOCAL_HOLD: begin
                grant_local = 1'b1;
                latch_en    = 1'b1;
            end
            default: ;
        endcase
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(byp_en && latch_en)); // R6
    AST_PASS_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        byp_en |-> (grant_dist != '0)); // R6
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_local, grant_dist})); // R9

endmodule

// File: rtl/smart_bypass_arbiter.sv
module smart_bypass_arbiter #(
    parameter int HPC = 7,
    localparam int HW = $clog2(HPC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              local_req,
    input  logic [HPC-1:0]    req_valid,
    input  logic [HPC*HW-1:0] req_hops,
    output logic              byp_en,
    output logic              latch_en,
    output logic              grant_local,
    output logic [HPC-1:0]    grant_dist
);

    logic [HPC-1:0] qual, last_hop, pick;
    logic           any;

    smart_req_qualify #(.HPC(HPC), .HW(HW)) qual_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hops(req_hops),
        .qual(qual), .last_hop(last_hop)
    );

    smart_near_pick #(.N(HPC)) pick_i (
        .clk(clk), .rst_n(rst_n), .qual(qual), .pick(pick), .any(any)
    );

    smart_bypass_fsm #(.N(HPC)) fsm_i (
        .clk(clk), .rst_n(rst_n), .local_req(local_req), .up_any(any),
        .up_pick(pick), .up_last(|(pick & last_hop)),
        .byp_en(byp_en), .latch_en(latch_en), .grant_local(grant_local),
        .grant_dist(grant_dist)
    );

    AST_LOCAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        local_req |=> (grant_local && grant_dist == '0)); // R3
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!local_req && req_valid == '0) |=>
        (!byp_en && !latch_en && !grant_local && grant_dist == '0)); // R8

endmodule

// File: tb/smart_bypass_arbiter_tb_top.sv
module smart_bypass_arbiter_tb_top;

    localparam int HPC = 3;
    localparam int HW  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              local_req = 1'b0;
    logic [HPC-1:0]    req_valid = '0;
    logic [HPC*HW-1:0] req_hops = '0;
    logic              byp_en, latch_en, grant_local;
    logic [HPC-1:0]    grant_dist;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    smart_bypass_arbiter #(.HPC(HPC)) dut_i (
        .clk(clk), .rst_n(rst_n), .local_req(local_req), .req_valid(req_valid),
        .req_hops(req_hops), .byp_en(byp_en), .latch_en(latch_en),
        .grant_local(grant_local), .grant_dist(grant_dist)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_zero(input string tag);
        chk(tag, {byp_en, latch_en, grant_local, grant_dist}, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int win, wh, e_byp, e_lat, e_gl, e_gd;
        logic [HW-1:0] h;
        repeat (3) @(negedge clk);
        chk_zero("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_zero("R1 after reset");

        for (int c = 0; c < 1024; c++) begin
            local_req = c[0];
            req_valid = c[3:1];
            req_hops  = c[9:4];
            win = 0;
            wh  = 0;
            for (int d = 1; d <= HPC; d++) begin
                h = req_hops[(d-1)*HW +: HW];
                if (win == 0 && req_valid[d-1] && int'(h) >= d) begin
                    win = d;
                    wh  = int'(h);
                end
            end
            e_gl  = local_req ? 1 : 0;
            e_gd  = (!local_req && win != 0) ? (1 << (win - 1)) : 0;
            e_byp = (!local_req && win != 0 && wh > win) ? 1 : 0;
            e_lat = ((!local_req && win != 0 && wh == win) ||
                     (local_req && win != 0)) ? 1 : 0;
            @(negedge clk);
            chk(local_req ? "R3 local grant" : "R5 local grant clear",
                int'(grant_local), e_gl);
            if (local_req)
                chk("R3 no lane grant", int'(grant_dist), e_gd);
            else if (win == 0 && req_valid != '0)
                chk("R2 short request ignored", int'(grant_dist), e_gd);
            else
                chk("R5 nearest lane", int'(grant_dist), e_gd);
            chk(local_req ? "R4 no bypass" : "R6 bypass flag", int'(byp_en), e_byp);
            chk(local_req ? "R4 incoming buffered" : "R7 land flag",
                int'(latch_en), e_lat);
            chk("R9 onehot grant",
                ($countones({grant_local, grant_dist}) <= 1) ? 1 : 0, 1);
        end

        // One-cycle lifetime: a local win followed by silence.
        local_req = 1'b1;
        req_valid = '0;
        @(negedge clk);
        chk("R8 decision present", int'(grant_local), 1);
        local_req = 1'b0;
        @(negedge clk);
        chk_zero("R8 cleared after one cycle");
        @(negedge clk);
        chk_zero("R8 stays idle");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule